// File: doc/BRIEF.md
# Mixed-Behavior Control/Status Register Bank

This block is a small bank of control and status registers behind a simple processor port. The port has an address, a write strobe, a read strobe, write data and registered read data. Five addresses are mapped. Most of them hold two nibble-wide fields, and each field has its own access behavior. Control fields drive module outputs. Status fields sample module inputs.

Within one address, a write or a read can have different side effects on each field. Every side effect is applied bit by bit. Event capture works for both polarities, and in both cases a new event wins over a clear that arrives in the same cycle. One trigger field produces a single-cycle strobe. Another trigger field raises a request that stays high until an acknowledge input returns.

All flops update on the rising clock edge and reset synchronously on an active-high reset. Field layout with the default NF=4 (bits [3:0] are the low field, bits [7:4] the high field):

- address 0: [3:0] mode (read/write), [7:4] key (write-only)
- address 1: [3:0] status input (read-only), [7:4] flags (write-1-to-set)
- address 2: [3:0] high-event capture (write-1-to-clear), [7:4] low-event capture (write-1-to-rearm)
- address 3: [3:0] hit capture (clear-on-read), [7:4] arm field (read/write, set-on-read)
- address 4: bit 0 go strobe, bit 1 request held until acknowledge
- all other addresses are unmapped

Top module: `csr_field_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every field takes its reset value: mode=4'h5, key=0, flags=0, high-event=0, low-event=4'hF, hit=0, arm=4'h3, go=0, req=0, and `rdata_o`=0.
- R2: A write to address 0 loads wdata[3:0] into the mode field, which drives `mode_o`. A read of address 0 returns it in bits [3:0].
- R3: A write to address 0 loads wdata[7:4] into the key field, which drives `key_o`. Bits [7:4] of a read of address 0 always return 0.
- R4: A read of address 1 returns the current `sts_i` in bits [3:0]. Writes have no effect on those bits.
- R5: A write to address 1 sets each bit of the flags field (`flags_o`, read at address 1 bits [7:4]) whose wdata[7:4] bit is 1. Flag bits written with 0 keep their value.
- R6: A high-event bit (address 2 bits [3:0]) becomes 1 after any cycle in which its `ev_hi_i` bit is 1, and holds until a write to address 2 with a 1 in that wdata bit clears it. Bits written with 0 are unchanged. If the event and the clear arrive in the same cycle, the bit stays 1.
- R7: A low-event bit (address 2 bits [7:4]) becomes 0 after any cycle in which its `ev_lo_i` bit is 0, and holds until a write to address 2 with a 1 in the matching wdata[7:4] bit rearms it to 1. If the event and the rearm arrive in the same cycle, the bit stays 0.
- R8: A hit bit (address 3 bits [3:0]) becomes 1 after any cycle in which its `hit_i` bit is 1. A read of address 3 returns the current hit value and then clears every hit bit, except a bit whose `hit_i` is 1 in that same cycle, which stays 1.
- R9: The arm field (`arm_o`, address 3 bits [7:4]) is loaded from wdata[7:4] by a write to address 3, and becomes all ones after a read of address 3. If a write and a read of address 3 coincide, the write takes effect.
- R10: Writing 1 to address 4 bit 0 makes `go_o` high for exactly the one cycle after that write. Bit 0 always reads as 0.
- R11: Writing 1 to address 4 bit 1 makes `req_o` high from the next cycle on. It stays high until the clock edge at which `ack_i` is sampled high, and then drops, unless a new set arrives in the same cycle. Bit 1 of a read of address 4 returns the state of `req_o`, and bits [7:2] read as 0.
- R12: `rdata_o` changes only at the edge that samples `rd_i` high, and becomes valid one cycle after the read strobe. Unmapped addresses read as 0, and writes to them change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| sts_i | input | NF | Read-only status input |
| ev_hi_i | input | NF | Events captured when 1 |
| ev_lo_i | input | NF | Events captured when 0 |
| hit_i | input | NF | Events for the clear-on-read field |
| ack_i | input | 1 | Acknowledge for the held request |
| mode_o | output | NF | Read/write mode field |
| key_o | output | NF | Write-only key field |
| flags_o | output | NF | Write-1-to-set flags |
| arm_o | output | NF | Set-on-read arm field |
| go_o | output | 1 | Single-cycle go strobe |
| req_o | output | 1 | Request held until acknowledge |

## Verification
The bench builds the bank with its defaults: AW=4 and NF=4, so DW=8. With four address bits, the unmapped addresses 5 to 15 can be reached directly, so writes and reads there can be aimed at them. Nibble-wide fields are wide enough for per-bit clears, per-bit sets and per-bit rearms to act on some bits of a field while leaving its neighbours untouched. This layout also puts every mix of side effects within reach of single writes and reads. The bench drives same-cycle collisions between an event and its clear, rearm or clearing read, and between a request set and its acknowledge.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_EVT  = 2;
  localparam int ADDR_HIT  = 3;
  localparam int ADDR_TRIG = 4;
  localparam int ADDR_LAST = ADDR_TRIG;

  localparam int TRIG_GO_BIT  = 0;
  localparam int TRIG_REQ_BIT = 1;

  typedef enum logic {POL_HIGH = 1'b0, POL_LOW = 1'b1} capture_pol_e;
endpackage

// File: rtl/csr_capture.sv
module csr_capture
  import csr_bank_pkg::*;
#(
  parameter int           W     = 4,
  parameter capture_pol_e POL   = POL_HIGH,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (POL == POL_HIGH) begin : g_high
      assign nxt[b] = ev_i[b] | (q_o[b] & ~clr_i[b]);
    end else begin : g_low
      assign nxt[b] = ev_i[b] & (q_o[b] | clr_i[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= RST_V;
    else     q_o <= nxt;
  end
endmodule

// File: rtl/csr_trigger.sv
module csr_trigger (
  input  logic clk,
  input  logic rst,
  input  logic go_set_i,
  input  logic req_set_i,
  input  logic ack_i,
  output logic go_o,
  output logic req_o
);
  logic req_nxt;

  always_comb begin
    req_nxt = req_o;
    if (ack_i)     req_nxt = 1'b0;
    if (req_set_i) req_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_o  <= 1'b0;
      req_o <= 1'b0;
    end else begin
      go_o  <= go_set_i;
      req_o <= req_nxt;
    end
  end
endmodule

// File: rtl/csr_read_port.sv
module csr_read_port #(
  parameter int NS = 5,
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [NS*DW-1:0]   slots_i,
  output logic [DW-1:0]      rdata_o
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int s = 0; s < NS; s++) begin
      if (addr_i == AW'(s)) sel = slots_i[s*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= sel;
  end
endmodule

// File: rtl/csr_field_bank.sv
module csr_field_bank
  import csr_bank_pkg::*;
#(
  parameter int            AW       = 4,
  parameter int            NF       = 4,
  parameter logic [NF-1:0] MODE_RST = NF'(5),
  parameter logic [NF-1:0] KEY_RST  = '0,
  parameter logic [NF-1:0] FLAG_RST = '0,
  parameter logic [NF-1:0] ARM_RST  = NF'(3),
  localparam int           DW       = 2 * NF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NF-1:0] sts_i,
  input  logic [NF-1:0] ev_hi_i,
  input  logic [NF-1:0] ev_lo_i,
  input  logic [NF-1:0] hit_i,
  input  logic          ack_i,
  output logic [NF-1:0] mode_o,
  output logic [NF-1:0] key_o,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] arm_o,
  output logic          go_o,
  output logic          req_o
);
  localparam int NSLOT = ADDR_LAST + 1;

  logic [NSLOT-1:0] hit_a;
  logic [NSLOT-1:0] wr_a;
  logic [NSLOT-1:0] rd_a;

  for (genvar a = 0; a < NSLOT; a++) begin : g_dec
    assign hit_a[a] = (addr_i == AW'(a));
    assign wr_a[a]  = wr_i & hit_a[a];
    assign rd_a[a]  = rd_i & hit_a[a];
  end

  logic [NF-1:0] wlo, whi;
  assign wlo = wdata_i[NF-1:0];
  assign whi = wdata_i[DW-1:NF];

  // plain, write-only, write-1-to-set and set-on-read fields
  logic [NF-1:0] mode_n, key_n, flags_n, arm_n;

  always_comb begin
    mode_n  = mode_o;
    key_n   = key_o;
    flags_n = flags_o;
    arm_n   = arm_o;
    if (wr_a[ADDR_CTRL]) begin
      mode_n = wlo;
      key_n  = whi;
    end
    if (wr_a[ADDR_STAT]) flags_n = flags_o | whi;
    if (rd_a[ADDR_HIT])  arm_n   = '1;
    if (wr_a[ADDR_HIT])  arm_n   = whi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o  <= MODE_RST;
      key_o   <= KEY_RST;
      flags_o <= FLAG_RST;
      arm_o   <= ARM_RST;
    end else begin
      mode_o  <= mode_n;
      key_o   <= key_n;
      flags_o <= flags_n;
      arm_o   <= arm_n;
    end
  end

  // event captures
  logic [NF-1:0] evh_q, evl_q, hit_q;

  csr_capture #(.W(NF), .POL(POL_HIGH), .RST_V('0)) u_evh (
    .clk(clk), .rst(rst), .ev_i(ev_hi_i),
    .clr_i(wr_a[ADDR_EVT] ? wlo : '0), .q_o(evh_q)
  );

  csr_capture #(.W(NF), .POL(POL_LOW), .RST_V('1)) u_evl (
    .clk(clk), .rst(rst), .ev_i(ev_lo_i),
    .clr_i(wr_a[ADDR_EVT] ? whi : '0), .q_o(evl_q)
  );

  csr_capture #(.W(NF), .POL(POL_HIGH), .RST_V('0)) u_hit (
    .clk(clk), .rst(rst), .ev_i(hit_i),
    .clr_i({NF{rd_a[ADDR_HIT]}}), .q_o(hit_q)
  );

  // triggers
  csr_trigger u_trig (
    .clk(clk), .rst(rst),
    .go_set_i(wr_a[ADDR_TRIG] & wdata_i[TRIG_GO_BIT]),
    .req_set_i(wr_a[ADDR_TRIG] & wdata_i[TRIG_REQ_BIT]),
    .ack_i(ack_i), .go_o(go_o), .req_o(req_o)
  );

  // read path
  logic [NSLOT*DW-1:0] slots;
  logic [DW-1:0]       trig_rd;

  always_comb begin
    trig_rd = '0;
    trig_rd[TRIG_REQ_BIT] = req_o;
  end

  assign slots[ADDR_CTRL*DW +: DW] = {{NF{1'b0}}, mode_o};
  assign slots[ADDR_STAT*DW +: DW] = {flags_o, sts_i};
  assign slots[ADDR_EVT*DW  +: DW] = {evl_q, evh_q};
  assign slots[ADDR_HIT*DW  +: DW] = {arm_o, hit_q};
  assign slots[ADDR_TRIG*DW +: DW] = trig_rd;

  csr_read_port #(.NS(NSLOT), .DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_i(rd_i), .addr_i(addr_i),
    .slots_i(slots), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/csr_field_bank_chk.sv
module csr_field_bank_chk
  import csr_bank_pkg::*;
#(
  parameter int AW = 4,
  parameter int NF = 4,
  localparam int DW = 2 * NF
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          ack_i,
  input logic [NF-1:0] arm_o,
  input logic          go_o,
  input logic          req_o
);
  logic wr_trig, unmapped;
  assign wr_trig  = wr_i && (addr_i == AW'(ADDR_TRIG));
  assign unmapped = (int'(addr_i) > ADDR_LAST);

  AST_GO_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    go_o |-> $past(wr_trig && wdata_i[TRIG_GO_BIT])); // R10

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> req_o); // R11

  AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i && !(wr_trig && wdata_i[TRIG_REQ_BIT])) |=> !req_o); // R11

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && unmapped) |=> (rdata_o == '0)); // R12

  AST_RDATA_STABLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o)); // R12

  AST_ARM_SET_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i && addr_i == AW'(ADDR_HIT)) |=> (arm_o == '1)); // R9
endmodule

bind csr_field_bank csr_field_bank_chk #(.AW(AW), .NF(NF)) u_chk (
  .clk(clk), .rst(rst), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i), .arm_o(arm_o),
  .go_o(go_o), .req_o(req_o)
);

// File: tb/tb_csr_field_bank.sv
`timescale 1ns/1ps
module tb_csr_field_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] sts_i = '0, ev_hi_i = '0, ev_lo_i = 4'hF, hit_i = '0;
  logic       ack_i = 1'b0;
  logic [3:0] mode_o, key_o, flags_o, arm_o;
  logic       go_o, req_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  csr_field_bank dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sts_i(sts_i), .ev_hi_i(ev_hi_i),
    .ev_lo_i(ev_lo_i), .hit_i(hit_i), .ack_i(ack_i), .mode_o(mode_o),
    .key_o(key_o), .flags_o(flags_o), .arm_o(arm_o), .go_o(go_o), .req_o(req_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per sampled read strobe
  always @(posedge clk) begin
    automatic logic fire = rd_i && !rst;
    #2;
    if (fire && exp_q.size() > 0) begin
      chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    addr_i = a; rd_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("R1 mode", {4'h0, mode_o}, 8'h05);
    chk("R1 key", {4'h0, key_o}, 8'h00);
    chk("R1 flags", {4'h0, flags_o}, 8'h00);
    chk("R1 arm", {4'h0, arm_o}, 8'h03);
    chk("R1 trig", {6'h0, req_o, go_o}, 8'h00);
    chk("R1 rdata", rdata_o, 8'h00);
    rd(4'd2, 8'hF0, "R1 event reset");
    rd(4'd3, 8'h30, "R1 hit/arm reset");
    chk("R9 arm after read", {4'h0, arm_o}, 8'h0F);
    // R12 hold without read strobe
    @(negedge clk);
    chk("R12 rdata held", rdata_o, 8'h30);

    // R2 / R3
    wr(4'd0, 8'hA7);
    chk("R2 mode_o", {4'h0, mode_o}, 8'h07);
    chk("R3 key_o", {4'h0, key_o}, 8'h0A);
    rd(4'd0, 8'h07, "R3 key reads zero");

    // R4 / R5
    sts_i = 4'h9;
    wr(4'd1, 8'h5F);
    chk("R5 flags set", {4'h0, flags_o}, 8'h05);
    rd(4'd1, 8'h59, "R4 status read");
    wr(4'd1, 8'h20);
    chk("R5 flags per bit", {4'h0, flags_o}, 8'h07);

    // R6 sticky high
    ev_hi_i = 4'b0110; @(negedge clk); ev_hi_i = '0;
    rd(4'd2, 8'hF6, "R6 capture");
    wr(4'd2, 8'h02);
    rd(4'd2, 8'hF4, "R6 per-bit clear");
    ev_hi_i = 4'b0100; wr(4'd2, 8'h04); ev_hi_i = '0;
    rd(4'd2, 8'hF4, "R6 event beats clear");
    wr(4'd2, 8'h04);
    rd(4'd2, 8'hF0, "R6 cleared");

    // R7 sticky low
    ev_lo_i = 4'b1101; @(negedge clk); ev_lo_i = 4'hF;
    rd(4'd2, 8'hD0, "R7 capture zero");
    ev_lo_i = 4'b1101; wr(4'd2, 8'h20); ev_lo_i = 4'hF;
    rd(4'd2, 8'hD0, "R7 event beats rearm");
    wr(4'd2, 8'h20);
    rd(4'd2, 8'hF0, "R7 rearm");

    // R8 / R9
    wr(4'd3, 8'h00);
    chk("R9 arm written", {4'h0, arm_o}, 8'h00);
    hit_i = 4'b1001; @(negedge clk); hit_i = '0;
    rd(4'd3, 8'h09, "R8 capture read");
    chk("R9 arm set on read", {4'h0, arm_o}, 8'h0F);
    rd(4'd3, 8'hF0, "R8 cleared on read");
    hit_i = 4'b0010; @(negedge clk);
    rd(4'd3, 8'hF2, "R8 read with event");
    hit_i = '0;
    rd(4'd3, 8'hF2, "R8 event beats read clear");
    rd(4'd3, 8'hF0, "R8 cleared");

    // R10 pulse
    wr(4'd4, 8'h01);
    chk("R10 go high", {7'h0, go_o}, 8'h01);
    @(negedge clk);
    chk("R10 go one cycle", {7'h0, go_o}, 8'h00);
    rd(4'd4, 8'h00, "R10 go reads zero");

    // R11 held request
    wr(4'd4, 8'h02);
    chk("R11 req set", {7'h0, req_o}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R11 req held", {7'h0, req_o}, 8'h01);
    rd(4'd4, 8'h02, "R11 req reads back");
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    chk("R11 req dropped", {7'h0, req_o}, 8'h00);
    rd(4'd4, 8'h00, "R11 req read after ack");

    // R12 unmapped
    wr(4'd5, 8'hFF);
    wr(4'd15, 8'hFF);
    chk("R12 mode untouched", {4'h0, mode_o}, 8'h07);
    chk("R12 flags untouched", {4'h0, flags_o}, 8'h07);
    chk("R12 trig untouched", {6'h0, req_o, go_o}, 8'h00);
    rd(4'd0, 8'h07, "R12 ctrl untouched");
    rd(4'd5, 8'h00, "R12 unmapped read");
    rd(4'd2, 8'hF0, "R12 events untouched");
    rd(4'd15, 8'h00, "R12 unmapped high read");
    repeat (2) @(negedge clk);

    if (exp_q.size() != 0) chk("R12 pending reads", 8'(exp_q.size()), 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule